// File: doc/BRIEF.md
# Programmable Raster Sync and Blank Generator

This block turns a pixel clock into the timing strobes of a video raster. A column counter steps through each line and a row counter steps through each frame. Every pulse edge comes from a value on the configuration inputs. The horizontal edges are columns within the line, and the vertical edges are rows within the frame. From these counts the block derives the horizontal and vertical blank and sync, and composite blank and sync. Composite sync can carry equalization and serration pulses, at one or two per line, over a programmable window of rows. The block also derives gating strobes, a cursor-area marker and a vertical interrupt window.

A control word sets four things: which of these signals drives each of four output pins, the active level of each pin, the scan mode, and whether counting runs at all. In interlaced scan the block alternates between an even and an odd field. It reports the current field on a separate flag. In the odd field all vertical events move half a line later.

Register loading sits outside this block. The configuration inputs are expected to change only while reset is held.

Top module: `vsg_top`

## Requirements
- R1: The column counter runs from 0 to `h_line_len`-1 and wraps to 0. At each wrap the row counter advances, and it wraps to 0 after `v_frame_len`-1. Both counters are 0 after reset.
- R2: Horizontal blank is active for columns below `h_blank_len`. Horizontal sync is active for columns from `h_sync_start` up to, but not including, `h_sync_stop`.
- R3: Vertical signals use an effective row. Normally the effective row is the row counter. In interlaced scan (`ctrl_word[4:3]`=00) during the odd field, for columns below `h_line_len`/2 (rounded down), the effective row is the previous row, and row 0 maps to `v_frame_len`-1. Vertical blank is active for effective rows below `v_blank_len`. Vertical sync is active for effective rows in [`v_sync_start`, `v_sync_stop`).
- R4: Composite blank is horizontal blank OR vertical blank. Outside the pulse window, composite sync is horizontal sync OR vertical sync.
- R5: When pulses are enabled and the effective row lies in [`eq_first_line`, `eq_last_line`], composite sync is driven from a pulse position. That position is the column in single mode (`ctrl_word[4:3]`=11). In double modes (00, 01, and 10, which is treated as 01) it is the column modulo half a line. On effective rows inside vertical sync, sync is active while the position is below `serr_stop`; on other rows it is active while the position is below `eq_stop`.
- R6: With `ctrl_word[9]`=1 the pulse window has no effect, and composite sync follows R4 on every row.
- R7: Horizontal gate is NOT horizontal blank. Vertical gate is NOT vertical blank. The cursor marker is horizontal gate AND vertical gate. The vertical interrupt is active for effective rows in [`vint_on_line`, `vint_off_line`).
- R8: `ctrl_word[2:0]` selects the signals on pins {vblank_mix, vsync_mix, hblank_mix, hsync_mix}: 0 {VB,VS,HB,HS}; 1 {CB,CS,HG,VG}; 2 {VB,CS,HB,HS}; 3 {CB,VS,CUR,VI}; 4 {VB,VS,CUR,VI}; 5 {CB,CS,HB,HS}; 6 {VB,CS,HG,VG}; 7 {CB,VS,HB,VI}.
- R9: `ctrl_word[5]`, `[6]`, `[7]` and `[8]` set the active level of the vblank_mix, vsync_mix, hblank_mix and hsync_mix pins. A 1 selects active high and a 0 selects active low.
- R10: With `ctrl_word[10]`=0 both counters and the field hold, and the pins keep their levels.
- R11: The field flag clears at reset and toggles at every frame wrap. `field_odd` shows the flag in interlaced scan and is held at 1 in the other modes.
- R12: Pins update on the falling clock edge from the counter state after the preceding rising edge. They never change at a rising edge. During reset they show the decode of row 0, column 0, even field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 11 | Select, mode, polarity, pulse-disable and enable bits |
| h_line_len | input | 12 | Clocks per line |
| h_sync_start | input | 12 | Column where horizontal sync starts (front porch end) |
| h_sync_stop | input | 12 | Column where horizontal sync ends |
| h_blank_len | input | 12 | Width of horizontal blank in clocks |
| v_frame_len | input | 12 | Lines per frame |
| v_sync_start | input | 12 | Row where vertical sync starts |
| v_sync_stop | input | 12 | Row where vertical sync ends |
| v_blank_len | input | 12 | Width of vertical blank in rows |
| eq_stop | input | 12 | End position of an equalization pulse |
| serr_stop | input | 12 | End position of a serration pulse |
| eq_first_line | input | 12 | First row of the pulse window |
| eq_last_line | input | 12 | Last row of the pulse window |
| vint_on_line | input | 12 | Row where the vertical interrupt starts |
| vint_off_line | input | 12 | Row where the vertical interrupt ends |
| pin_vblank_mix | output | 1 | Vertical or composite blank |
| pin_vsync_mix | output | 1 | Vertical or composite sync |
| pin_hblank_mix | output | 1 | Horizontal blank, horizontal gate or cursor |
| pin_hsync_mix | output | 1 | Horizontal sync, vertical gate or vertical interrupt |
| field_odd | output | 1 | Odd-field flag |

## Verification
A rising edge moves the counters. The next falling edge, half a cycle later, carries the new counter state to the pins, so every pin result is due in that same clock cycle. The bench keeps its own column, row and field model. It advances the model at each rising edge and compares the pins three quarters of a period after that edge, when the falling-edge register has already loaded. The bench also samples a quarter period after each rising edge and requires the pins to equal the previous late sample, which confirms that nothing moves at the rising edge.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int CTRL_W     = 11;
  localparam int ST_SEL_LO  = 0;
  localparam int ST_MODE_LO = 3;
  localparam int ST_POL_LO  = 5;
  localparam int ST_EQ_OFF  = 9;
  localparam int ST_RUN     = 10;

  typedef enum logic [1:0] {
    SCAN_ILACE_DBL = 2'b00,
    SCAN_PROG_DBL  = 2'b01,
    SCAN_RSVD      = 2'b10,
    SCAN_PROG_SGL  = 2'b11
  } scan_mode_e;

  typedef struct packed {
    logic vblank;
    logic cblank;
    logic vsync;
    logic csync;
    logic hblank;
    logic hgate;
    logic cursor;
    logic hsync;
    logic vgate;
    logic vint;
  } raw_sigs_t;
endpackage

// File: rtl/vsg_hcount.sv
module vsg_hcount #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] h_total,
  output logic [W-1:0] hc,
  output logic         line_end
);
  logic last_col;

  assign last_col = (hc >= h_total - W'(1));
  assign line_end = en & last_col;

  always_ff @(posedge clk) begin
    if (rst)      hc <= '0;
    else if (en)  hc <= last_col ? '0 : hc + W'(1);
  end

  p_hc_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (en && last_col) |=> (hc == '0));
  p_hc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (en && !last_col) |=> (hc == $past(hc) + W'(1)));
  p_hc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(hc));
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         line_end,
  input  logic [W-1:0] v_total,
  output logic [W-1:0] vc,
  output logic         field
);
  logic last_row;
  logic frame_end;

  assign last_row  = (vc >= v_total - W'(1));
  assign frame_end = line_end & last_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      vc    <= '0;
      field <= 1'b0;
    end else if (line_end) begin
      vc <= last_row ? '0 : vc + W'(1);
      if (last_row) field <= ~field;
    end
  end

  p_vc_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (vc == '0));
  p_vc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (line_end && !last_row) |=> (vc == $past(vc) + W'(1)));
  p_vc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(vc) && $stable(field)));
  p_field_flip_r11: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (field != $past(field)));
  p_field_keep_r11: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(field));
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
  import vsg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] hc,
  input  logic [W-1:0] vc,
  input  logic         field,
  input  logic [9:0]   ctrl,
  input  logic [W-1:0] h_total,
  input  logic [W-1:0] h_sync_start,
  input  logic [W-1:0] h_sync_stop,
  input  logic [W-1:0] h_blank_len,
  input  logic [W-1:0] v_total,
  input  logic [W-1:0] v_sync_start,
  input  logic [W-1:0] v_sync_stop,
  input  logic [W-1:0] v_blank_len,
  input  logic [W-1:0] eq_stop,
  input  logic [W-1:0] serr_stop,
  input  logic [W-1:0] eq_first,
  input  logic [W-1:0] eq_last,
  input  logic [W-1:0] vint_on,
  input  logic [W-1:0] vint_off,
  output logic [3:0]   pins,
  output logic         odd_flag
);
  scan_mode_e mode;
  raw_sigs_t  s;
  logic         interlaced, single, late_half, in_win;
  logic [W-1:0] half, veff, pos;
  logic [3:0]   pick, pol;

  assign mode       = scan_mode_e'(ctrl[ST_MODE_LO +: 2]);
  assign interlaced = (mode == SCAN_ILACE_DBL);
  assign single     = (mode == SCAN_PROG_SGL);
  assign half       = h_total >> 1;
  assign late_half  = interlaced && field && (hc < half);
  assign veff       = !late_half ? vc : ((vc == '0) ? v_total - W'(1) : vc - W'(1));
  assign pos        = single ? hc : ((hc >= half) ? hc - half : hc);
  assign in_win     = !ctrl[ST_EQ_OFF] && (veff >= eq_first) && (veff <= eq_last);

  always_comb begin
    s.hblank = (hc < h_blank_len);
    s.hsync  = (hc >= h_sync_start) && (hc < h_sync_stop);
    s.vblank = (veff < v_blank_len);
    s.vsync  = (veff >= v_sync_start) && (veff < v_sync_stop);
    s.cblank = s.hblank | s.vblank;
    if (in_win) s.csync = s.vsync ? (pos < serr_stop) : (pos < eq_stop);
    else        s.csync = s.hsync | s.vsync;
    s.hgate  = ~s.hblank;
    s.vgate  = ~s.vblank;
    s.cursor = s.hgate & s.vgate;
    s.vint   = (veff >= vint_on) && (veff < vint_off);
  end

  always_comb begin
    case (ctrl[ST_SEL_LO +: 3])
      3'd0:    pick = {s.vblank, s.vsync, s.hblank, s.hsync};
      3'd1:    pick = {s.cblank, s.csync, s.hgate,  s.vgate};
      3'd2:    pick = {s.vblank, s.csync, s.hblank, s.hsync};
      3'd3:    pick = {s.cblank, s.vsync, s.cursor, s.vint};
      3'd4:    pick = {s.vblank, s.vsync, s.cursor, s.vint};
      3'd5:    pick = {s.cblank, s.csync, s.hblank, s.hsync};
      3'd6:    pick = {s.vblank, s.csync, s.hgate,  s.vgate};
      default: pick = {s.cblank, s.vsync, s.hblank, s.vint};
    endcase
  end

  assign pol      = {ctrl[ST_POL_LO], ctrl[ST_POL_LO+1], ctrl[ST_POL_LO+2], ctrl[ST_POL_LO+3]};
  assign pins     = pick ^ ~pol;
  assign odd_flag = interlaced ? field : 1'b1;
endmodule

// File: rtl/vsg_top.sv
module vsg_top
  import vsg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [W-1:0]      h_line_len,
  input  logic [W-1:0]      h_sync_start,
  input  logic [W-1:0]      h_sync_stop,
  input  logic [W-1:0]      h_blank_len,
  input  logic [W-1:0]      v_frame_len,
  input  logic [W-1:0]      v_sync_start,
  input  logic [W-1:0]      v_sync_stop,
  input  logic [W-1:0]      v_blank_len,
  input  logic [W-1:0]      eq_stop,
  input  logic [W-1:0]      serr_stop,
  input  logic [W-1:0]      eq_first_line,
  input  logic [W-1:0]      eq_last_line,
  input  logic [W-1:0]      vint_on_line,
  input  logic [W-1:0]      vint_off_line,
  output logic              pin_vblank_mix,
  output logic              pin_vsync_mix,
  output logic              pin_hblank_mix,
  output logic              pin_hsync_mix,
  output logic              field_odd
);
  logic         run, line_end, field, odd_d;
  logic [W-1:0] hc, vc;
  logic [3:0]   pins_d;

  assign run = ctrl_word[ST_RUN];

  vsg_hcount #(.W(W)) u_h (
    .clk(clk), .rst(rst), .en(run), .h_total(h_line_len),
    .hc(hc), .line_end(line_end)
  );

  vsg_vcount #(.W(W)) u_v (
    .clk(clk), .rst(rst), .en(run), .line_end(line_end),
    .v_total(v_frame_len), .vc(vc), .field(field)
  );

  vsg_decode #(.W(W)) u_dec (
    .hc(hc), .vc(vc), .field(field), .ctrl(ctrl_word[9:0]),
    .h_total(h_line_len), .h_sync_start(h_sync_start), .h_sync_stop(h_sync_stop),
    .h_blank_len(h_blank_len), .v_total(v_frame_len), .v_sync_start(v_sync_start),
    .v_sync_stop(v_sync_stop), .v_blank_len(v_blank_len), .eq_stop(eq_stop),
    .serr_stop(serr_stop), .eq_first(eq_first_line), .eq_last(eq_last_line),
    .vint_on(vint_on_line), .vint_off(vint_off_line),
    .pins(pins_d), .odd_flag(odd_d)
  );

  // Pins load on the falling edge from the state the rising edge left (R12)
  always_ff @(negedge clk) begin
    {pin_vblank_mix, pin_vsync_mix, pin_hblank_mix, pin_hsync_mix} <= pins_d;
    field_odd <= odd_d;
  end
endmodule

// File: tb/tb_vsg_top.sv
module tb_vsg_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [10:0] ctrl_word = '0;
  logic [W-1:0] h_line_len, h_sync_start, h_sync_stop, h_blank_len;
  logic [W-1:0] v_frame_len, v_sync_start, v_sync_stop, v_blank_len;
  logic [W-1:0] eq_stop, serr_stop, eq_first_line, eq_last_line, vint_on_line, vint_off_line;
  logic pin_vblank_mix, pin_vsync_mix, pin_hblank_mix, pin_hsync_mix, field_odd;

  int tests = 0, fails = 0;
  int m_hc = 0, m_vc = 0;
  bit m_fld = 0;
  bit have_prev = 0;
  logic [4:0] prev;
  bit done = 0;

  vsg_top #(.W(W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b (hc=%0d vc=%0d)", tag, got, exp, m_hc, m_vc);
    end
  endtask

  function automatic logic [4:0] model_out();
    int htot = int'(h_line_len), vtot = int'(v_frame_len), half, veff, p;
    bit il, sgl, hb, hs, vb, vs, win, cs, cb, hg, vg, cur, vi;
    logic [3:0] pk, pol;
    half = htot / 2;
    il   = (ctrl_word[4:3] == 2'b00);
    sgl  = (ctrl_word[4:3] == 2'b11);
    veff = (il && m_fld && m_hc < half) ? ((m_vc == 0) ? vtot - 1 : m_vc - 1) : m_vc;
    hb = m_hc < int'(h_blank_len);
    hs = m_hc >= int'(h_sync_start) && m_hc < int'(h_sync_stop);
    vb = veff < int'(v_blank_len);
    vs = veff >= int'(v_sync_start) && veff < int'(v_sync_stop);
    win = !ctrl_word[9] && veff >= int'(eq_first_line) && veff <= int'(eq_last_line);
    p  = sgl ? m_hc : ((m_hc >= half) ? m_hc - half : m_hc);
    cs = win ? (vs ? (p < int'(serr_stop)) : (p < int'(eq_stop))) : (hs || vs);
    cb = hb || vb; hg = !hb; vg = !vb; cur = hg && vg;
    vi = veff >= int'(vint_on_line) && veff < int'(vint_off_line);
    case (ctrl_word[2:0])
      3'd0: pk = {vb, vs, hb, hs};
      3'd1: pk = {cb, cs, hg, vg};
      3'd2: pk = {vb, cs, hb, hs};
      3'd3: pk = {cb, vs, cur, vi};
      3'd4: pk = {vb, vs, cur, vi};
      3'd5: pk = {cb, cs, hb, hs};
      3'd6: pk = {vb, cs, hg, vg};
      default: pk = {cb, vs, hb, vi};
    endcase
    for (int i = 0; i < 4; i++) pol[3-i] = ctrl_word[5+i];
    for (int i = 0; i < 4; i++) pk[i] = pol[i] ? pk[i] : ~pk[i];
    return {pk, il ? m_fld : 1'b1};
  endfunction

  task automatic step(input string tag);
    logic [4:0] got, exp;
    @(posedge clk);
    if (rst) begin
      m_hc = 0; m_vc = 0; m_fld = 0;
    end else if (ctrl_word[10]) begin
      if (m_hc >= int'(h_line_len) - 1) begin
        m_hc = 0;
        if (m_vc >= int'(v_frame_len) - 1) begin m_vc = 0; m_fld = ~m_fld; end
        else m_vc++;
      end else m_hc++;
    end
    #(CLK_PERIOD/4);
    got = {pin_vblank_mix, pin_vsync_mix, pin_hblank_mix, pin_hsync_mix, field_odd};
    if (have_prev) chk("R12 no change at rising edge", got, prev);
    #(CLK_PERIOD/2);
    got = {pin_vblank_mix, pin_vsync_mix, pin_hblank_mix, pin_hsync_mix, field_odd};
    exp = model_out();
    chk(tag, {got[4:1], 1'b0}, {exp[4:1], 1'b0});
    chk("R11 field flag", {4'b0, got[0]}, {4'b0, exp[0]});
    prev = got; have_prev = 1;
  endtask

  task automatic base_timing();
    h_line_len = 40; h_sync_start = 4; h_sync_stop = 8; h_blank_len = 10;
    v_frame_len = 20; v_sync_start = 3; v_sync_stop = 6; v_blank_len = 8;
    eq_stop = 2; serr_stop = 17; eq_first_line = 1; eq_last_line = 9;
    vint_on_line = 12; vint_off_line = 15;
  endtask

  function automatic logic [10:0] mk(bit run, bit eqoff, logic [3:0] pol, logic [1:0] mode, logic [2:0] sel);
    return {run, eqoff, pol, mode, sel};
  endfunction

  task automatic run_cfg(input logic [10:0] cw, input int n, input string tag);
    rst = 1; ctrl_word = cw;
    for (int i = 0; i < 3; i++) step("R12 reset state R1");
    rst = 0;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    base_timing();
    run_cfg(mk(1, 0, 4'b0101, 2'b01, 3'd0), 1700, "R1 R2 R3 R8 R9");
    run_cfg(mk(1, 0, 4'b1111, 2'b00, 3'd1), 2500, "R3 R4 R5 R7 R11 interlaced");
    run_cfg(mk(1, 0, 4'b1010, 2'b11, 3'd3), 1700, "R5 R7 single mode");
    run_cfg(mk(1, 0, 4'b0011, 2'b10, 3'd5), 1700, "R5 mode 10 as double");
    run_cfg(mk(1, 1, 4'b1100, 2'b01, 3'd2), 1700, "R6 R4 pulses disabled");
    run_cfg(mk(1, 0, 4'b0110, 2'b00, 3'd6), 2500, "R3 R8 R11 odd field half-line");
    run_cfg(mk(1, 0, 4'b1001, 2'b00, 3'd4), 900, "R7 R8");
    ctrl_word[10] = 1'b0;
    for (int i = 0; i < 60; i++) step("R10 frozen");
    ctrl_word[10] = 1'b1;
    for (int i = 0; i < 200; i++) step("R10 resumed");
    run_cfg(mk(0, 0, 4'b1111, 2'b00, 3'd7), 80, "R10 never started");
    for (int k = 0; k < 15; k++) begin
      int ht = 16 + int'($urandom % 40);
      int vt = 6 + int'($urandom % 20);
      h_line_len = W'(ht); v_frame_len = W'(vt);
      h_blank_len = W'($urandom % ht); h_sync_start = W'($urandom % ht);
      h_sync_stop = W'($urandom % (ht + 1)); eq_stop = W'($urandom % ht);
      serr_stop = W'($urandom % ht); v_blank_len = W'($urandom % vt);
      v_sync_start = W'($urandom % vt); v_sync_stop = W'($urandom % (vt + 1));
      eq_first_line = W'($urandom % vt); eq_last_line = W'($urandom % vt);
      vint_on_line = W'($urandom % vt); vint_off_line = W'($urandom % (vt + 1));
      run_cfg(mk(1, 1'($urandom), 4'($urandom), 2'($urandom), 3'($urandom)),
              ht * vt * 2 + 20, "R2 R3 R5 R8 R9 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule